// File: doc/BRIEF.md
# Ones-complement ring adder

This block adds two operands in ones-complement arithmetic in a single pass. An ordinary adder has a fixed carry into its lowest bit. Here, the carry into every bit, including bit 0, is formed from generate and propagate terms taken around the word as a closed ring. The end-around carry therefore needs no second addition, and every bit position sees the same depth of lookahead logic. The word is built from equal groups of bits. Each group summarises itself as a group generate and a group propagate, and the carry into each group is resolved cyclically over those summaries.

Operands arrive on a valid/ready stream and the sum leaves on another. A parameter selects one of two output modes. In the registered mode, a single output stage holds the result. That stage accepts a new pair whenever it is empty or its content is being taken in the same cycle, and it holds its result unchanged while the consumer stalls. In the pass-through mode, the adder is purely combinational: valid and ready flow straight through, with no latency and no storage.

Top module: `ones_ring_adder`

## Requirements
- R1: `out_sum` equals the ones-complement sum of the operands. That sum is the two's-complement sum truncated to WIDTH bits, plus the carry-out of that sum added back in.
- R2: When `in_b` is the bitwise complement of `in_a`, the sum is all ones (0xFFFF at WIDTH 16).
- R3: When one operand is all ones, the sum equals the other operand, except that a zero other operand gives all ones.
- R4: The sum is all zeros only when both operands are all zeros.
- R5: Exchanging the operands leaves the sum unchanged.
- R6: In registered mode (REG_OUT=1), a pair accepted at a clock edge appears on `out_sum` with `out_valid` high after that same edge. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` stay unchanged.
- R7: In registered mode, `in_ready` is high exactly when the output stage is empty or `out_ready` is high.
- R8: In registered mode, after reset `out_valid` is low and `in_ready` is high.
- R9: In pass-through mode (REG_OUT=0), `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, and `out_sum` is the sum of the present operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage and the checks |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take the operand pair |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Sum is present |
| out_ready | input | 1 | Consumer takes the sum |
| out_sum | output | WIDTH | Ones-complement sum |

## Verification
The bench builds three copies of the block. The first is registered with WIDTH 16 and GROUP 4, which exercises the stream rules (R6 to R8) through stalls and back-to-back transfers. The second is a 16-bit pass-through copy, swept over every value of one operand against its complement and against all ones, plus random pairs in both operand orders and the 0x0000/0xFFFF/0x8000 corners. The third is an 8-bit pass-through copy with 2-bit groups. It is small enough that all 65,536 operand pairs are compared with the arithmetic reference, so every ring carry pattern, including the all-propagate ring with no generate, is covered.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GROUP = 4;
endpackage

// File: rtl/ora_group_slice.sv
// One group of bits: local lookahead from the group's carry-in,
// sum bits, and the group generate/propagate summary.
module ora_group_slice #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] op_a,
  input  logic [GW-1:0] op_b,
  input  logic          carry_in,
  output logic [GW-1:0] sum,
  output logic          grp_gen,
  output logic          grp_prop
);
  logic [GW-1:0] gen;
  logic [GW-1:0] prop;
  logic [GW-1:0] cin_bit;

  assign gen  = op_a & op_b;
  assign prop = op_a | op_b;

  always_comb begin : lookahead
    logic acc;
    logic term;
    for (int j = 0; j < GW; j++) begin
      term = carry_in;
      for (int m = 0; m < j; m++) term = term & prop[m];
      acc = term;
      for (int m = 0; m < j; m++) begin
        term = gen[m];
        for (int k = m + 1; k < j; k++) term = term & prop[k];
        acc = acc | term;
      end
      cin_bit[j] = acc;
    end
  end

  always_comb begin : summary
    logic acc;
    logic term;
    acc = 1'b0;
    for (int m = 0; m < GW; m++) begin
      term = gen[m];
      for (int k = m + 1; k < GW; k++) term = term & prop[k];
      acc = acc | term;
    end
    grp_gen = acc;
  end

  assign grp_prop = &prop;
  assign sum      = op_a ^ op_b ^ cin_bit;
endmodule

// File: rtl/ora_ring_carry.sv
// Cyclic lookahead: the carry into slot i gathers every generate
// around the ring, each gated by the propagates between it and i.
module ora_ring_carry #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  output logic [N-1:0] cin
);
  always_comb begin : ring
    logic acc;
    logic term;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int k = 1; k <= N; k++) begin
        term = gen[(i - k + N) % N];
        for (int j = 1; j < k; j++) term = term & prop[(i - j + N) % N];
        acc = acc | term;
      end
      cin[i] = acc;
    end
  end
endmodule

// File: rtl/ones_ring_adder.sv
module ones_ring_adder
  import ocr_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,
  parameter int unsigned GROUP   = DEF_GROUP,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum
);
  localparam int unsigned NGRP = WIDTH / GROUP;

  logic [NGRP-1:0]  grp_gen;
  logic [NGRP-1:0]  grp_prop;
  logic [NGRP-1:0]  grp_cin;
  logic [WIDTH-1:0] ring_sum;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    ora_group_slice #(.GW(GROUP)) u_slice (
      .op_a     (in_a[g*GROUP +: GROUP]),
      .op_b     (in_b[g*GROUP +: GROUP]),
      .carry_in (grp_cin[g]),
      .sum      (ring_sum[g*GROUP +: GROUP]),
      .grp_gen  (grp_gen[g]),
      .grp_prop (grp_prop[g])
    );
  end

  ora_ring_carry #(.N(NGRP)) u_ring (
    .gen  (grp_gen),
    .prop (grp_prop),
    .cin  (grp_cin)
  );

  // Two-pass reference used only by the checks below.
  logic [WIDTH:0]   ref_wide;
  logic [WIDTH-1:0] ref_sum;
  assign ref_wide = {1'b0, in_a} + {1'b0, in_b};
  assign ref_sum  = ref_wide[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, ref_wide[WIDTH]};

  // R1
  ring_matches_twopass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_sum == ref_sum);
  // R2
  complement_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_a == ~in_b) |-> (ring_sum == {WIDTH{1'b1}}));
  // R3
  ones_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_b == {WIDTH{1'b1}}) && (in_a != '0)) |-> (ring_sum == in_a));
  // R4
  zero_only_from_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_sum == '0) |-> ((in_a == '0) && (in_b == '0)));

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] sum_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        sum_q <= '0;
      end else if (in_valid && in_ready) begin
        vld_q <= 1'b1;
        sum_q <= ring_sum;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    assign out_valid = vld_q;
    assign out_sum   = sum_q;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));
    // R6
    load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && (out_sum == $past(ref_sum))));
    // R7
    accept_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_sum   = ring_sum;
  end
endmodule

// File: tb/ones_ring_adder_tb.sv
module ones_ring_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // registered 16-bit copy
  logic        r_iv = 0, r_or = 0;
  logic [15:0] r_a = 0, r_b = 0;
  logic        r_ir, r_ov;
  logic [15:0] r_s;
  ones_ring_adder #(.WIDTH(16), .GROUP(4), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(r_iv), .in_ready(r_ir), .in_a(r_a), .in_b(r_b),
    .out_valid(r_ov), .out_ready(r_or), .out_sum(r_s));

  // pass-through 16-bit copy
  logic        c_iv = 0, c_or = 0;
  logic [15:0] c_a = 0, c_b = 0;
  logic        c_ir, c_ov;
  logic [15:0] c_s;
  ones_ring_adder #(.WIDTH(16), .GROUP(4), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(c_iv), .in_ready(c_ir), .in_a(c_a), .in_b(c_b),
    .out_valid(c_ov), .out_ready(c_or), .out_sum(c_s));

  // pass-through 8-bit copy, 2-bit groups
  logic       s_ir, s_ov;
  logic [7:0] s_a = 0, s_b = 0, s_s;
  ones_ring_adder #(.WIDTH(8), .GROUP(2), .REG_OUT(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_ready(s_ir), .in_a(s_a), .in_b(s_b),
    .out_valid(s_ov), .out_ready(1'b1), .out_sum(s_s));

  function automatic int ones_sum(int a, int b, int w);
    int m;
    int s;
    m = (1 << w) - 1;
    s = a + b;
    if (s > m) s = s - m;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  int corners[3] = '{0, 'hFFFF, 'h8000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 out_valid after reset", int'(r_ov), 0);
    chk("R8 in_ready after reset", int'(r_ir), 1);

    // R1 exhaustive 8-bit sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        s_a = 8'(a); s_b = 8'(b);
        #1;
        chk("R1 8-bit exhaustive", int'(s_s), ones_sum(a, b, 8));
      end
    end

    // R2 and R3 full sweeps at 16 bits
    c_iv = 1'b1; c_or = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      c_a = 16'(a); c_b = ~16'(a);
      #1;
      chk("R2 complement operand", int'(c_s), 'hFFFF);
      c_b = 16'hFFFF;
      #1;
      chk("R3 all-ones operand", int'(c_s), (a == 0) ? 'hFFFF : a);
      if (c_s == 16'h0) chk("R4 zero only from zeros", a, 0);
    end

    // R4 zero pair
    c_a = 0; c_b = 0; #1;
    chk("R4 zero plus zero", int'(c_s), 0);

    // R1 corners, R5 operand exchange
    foreach (corners[i]) foreach (corners[j]) begin
      c_a = 16'(corners[i]); c_b = 16'(corners[j]); #1;
      chk("R1 corner pair", int'(c_s), ones_sum(corners[i], corners[j], 16));
    end
    for (int n = 0; n < 20000; n++) begin
      int a;
      int b;
      int s1;
      a = int'($urandom_range(0, 65535));
      b = int'($urandom_range(0, 65535));
      c_a = 16'(a); c_b = 16'(b); #1;
      s1 = int'(c_s);
      chk("R1 random pair", s1, ones_sum(a, b, 16));
      c_a = 16'(b); c_b = 16'(a); #1;
      chk("R5 exchanged operands", int'(c_s), s1);
    end

    // R9 pass-through handshake
    c_iv = 1'b1; c_or = 1'b0; #1;
    chk("R9 out_valid follows in_valid", int'(c_ov), 1);
    chk("R9 in_ready follows out_ready", int'(c_ir), 0);
    c_iv = 1'b0; c_or = 1'b1; #1;
    chk("R9 out_valid low", int'(c_ov), 0);
    chk("R9 in_ready high", int'(c_ir), 1);

    // R6/R7 registered stream
    @(negedge clk);
    r_iv = 1; r_or = 1; r_a = 16'h1234; r_b = 16'hF00F;
    @(negedge clk);
    chk("R6 out_valid after accept", int'(r_ov), 1);
    chk("R6 sum after accept", int'(r_s), ones_sum('h1234, 'hF00F, 16));
    r_a = 16'hFFFF; r_b = 16'h8000; r_or = 0;
    #1;
    chk("R7 in_ready low while full and stalled", int'(r_ir), 0);
    @(negedge clk);
    chk("R6 hold valid in stall", int'(r_ov), 1);
    chk("R6 hold sum in stall", int'(r_s), ones_sum('h1234, 'hF00F, 16));
    r_or = 1;
    #1;
    chk("R7 in_ready with out_ready", int'(r_ir), 1);
    @(negedge clk);
    chk("R6 sum after stall released", int'(r_s), ones_sum('hFFFF, 'h8000, 16));
    r_iv = 0;
    @(negedge clk);
    chk("R6 out_valid drains", int'(r_ov), 0);
    chk("R7 in_ready when empty", int'(r_ir), 1);

    // R6 back-to-back random transfers
    begin
      int pa;
      int pb;
      pa = 0; pb = 0;
      for (int n = 0; n < 300; n++) begin
        int a;
        int b;
        a = int'($urandom_range(0, 65535));
        b = int'($urandom_range(0, 65535));
        r_iv = 1; r_a = 16'(a); r_b = 16'(b);
        @(negedge clk);
        chk("R6 burst valid", int'(r_ov), 1);
        chk("R6 burst sum", int'(r_s), ones_sum(a, b, 16));
        pa = a; pb = b;
      end
      r_iv = 0;
      @(negedge clk);
      chk("R6 burst end", int'(r_ov), 0);
      if (pa < 0 || pb < 0) chk("R6 burst operands", 0, 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule